// File: doc/BRIEF.md
# Four-Slot Controller Port Multitap Router

This block sits between a single host controller port and four downstream slots. Each slot holds one controller and one memory card. The host moves one byte per step by raising `step_valid` with a byte on `step_byte`. One cycle later the block answers with `rsp_byte` and an acknowledge flag on `rsp_ack`. A step that returns no acknowledge ends the current sequence.

The first byte of a sequence picks a slot and a device class. The block then relays bytes to the chosen device until that device stops acknowledging. Downstream devices are byte-exchange ports that answer within the same cycle: the block pulses a per-slot strobe with a byte, and the device returns a reply byte and an ack.

A request-byte flag can arm a burst mode for the next controller sequence. In that sequence the block answers the command and request bytes on its own. It then streams 32 bytes out of an internal buffer, eight per slot, which hold the replies gathered during the previous burst. At the same time it refills each entry from the controllers.

Top module: `mtap_router`

## Requirements
- R1: In idle, a first byte of 0x01..0x04 selects controller slot (byte-1). The block sends 0x01 to that controller and returns its reply byte and ack. On ack the sequence moves to the command step.
- R2: In idle, a first byte of 0x81..0x84 selects card slot (byte-0x81). The block sends 0x81 to that card and returns its reply and ack. On ack it enters card relay. At most one card strobe and never a controller strobe is active in the same cycle.
- R3: In idle, any other first byte, or a selected slot whose device is absent (`*_present` low), returns 0xFF with no ack. No device is strobed and the block stays idle.
- R4: Without burst mode, the command byte and later data bytes are relayed unchanged. The request step sends 0x00 to the controller. Card and controller relay end, and the block returns to idle, on the first step the device does not ack.
- R5: With burst mode armed, the command step returns 0x80 with ack. The command counts as invalid unless the byte is 0x42.
- R6: With burst mode armed, the request step returns 0x5A. It acks only for a valid command. On ack the burst phase starts at slot 0; without ack the block goes idle.
- R7: Bit 0 of every request byte arms (1) or disarms (0) burst mode for the next sequence. The setting survives the end of the sequence.
- R8: While burst mode is armed, a controller selection that acks also sends 0x01, in the same step, to every other present controller.
- R9: Burst step n (0..31) returns buffer entry n with ack. It then stores into entry n the reply of the controller in slot n/8 to the host byte. Once that controller has withheld its ack (or is absent), 0xFF is stored instead and the controller is no longer strobed.
- R10: After every eighth burst step the done flag clears and the slot advances. The step that finishes slot 3 returns no ack, and the block goes idle.
- R11: Reset fills the buffer with 0xFF, disarms burst mode, and leaves the block idle with `rsp_valid` low.
- R12: Every step produces exactly one response, with `rsp_valid` high in the cycle after the step and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Host presents a byte this cycle |
| step_byte | input | 8 | Host byte |
| rsp_valid | output | 1 | Response for the previous step |
| rsp_byte | output | 8 | Response byte |
| rsp_ack | output | 1 | Acknowledge of the previous step |
| pad_strobe | output | NSLOT | Per-slot controller byte strobe |
| pad_tx | output | 8 | Byte sent to strobed controllers |
| pad_rx | input | NSLOT*8 | Controller reply bytes, slot s at bits 8s+7..8s |
| pad_ack | input | NSLOT | Controller acknowledges |
| pad_present | input | NSLOT | Controller fitted in slot |
| card_strobe | output | NSLOT | Per-slot card byte strobe |
| card_tx | output | 8 | Byte sent to the strobed card |
| card_rx | input | NSLOT*8 | Card reply bytes, slot s at bits 8s+7..8s |
| card_ack | input | NSLOT | Card acknowledges |
| card_present | input | NSLOT | Card fitted in slot |

## Verification
The bench builds the router with its defaults: four slots and eight bytes per slot, which gives a 32-entry buffer. These values let a burst reach the full slot wrap and the final step that returns no ack. They also cover a controller that answers longer than eight bytes (cut at the slot boundary), one that stops early (0xFF fill), and an absent slot. Two bursts run back to back so the second replays what the first gathered. An invalid command then disarms the mode, and the next sequence shows plain relay again.

// File: rtl/mtap_pkg.sv
package mtap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CARD,
        ST_CMD,
        ST_REQ,
        ST_SINGLE,
        ST_BURST
    } mtap_state_e;

    localparam logic [7:0] PAD_ACCESS  = 8'h01;
    localparam logic [7:0] CARD_ACCESS = 8'h81;
    localparam logic [7:0] BURST_CMD   = 8'h42;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;

    typedef struct packed {
        logic       hit_pad;
        logic       hit_card;
        logic [7:0] idx;
    } sel_t;

    typedef struct packed {
        logic [7:0] data;
        logic       ack;
    } reply_t;

    // Opening byte: bit 7 picks card versus controller, low bits give slot+1.
    function automatic sel_t decode_first(input logic [7:0] b, input int nslot);
        sel_t s;
        s = '0;
        if (int'(b[6:0]) >= 1 && int'(b[6:0]) <= nslot) begin
            s.idx      = {1'b0, b[6:0]} - 8'd1;
            s.hit_pad  = ~b[7];
            s.hit_card = b[7];
        end
        return s;
    endfunction

endpackage

// File: rtl/mtap_port_fanout.sv
module mtap_port_fanout
    import mtap_pkg::*;
#(
    parameter  int NSLOT  = 4,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                 en,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [NSLOT-1:0]     extra,
    input  logic [NSLOT-1:0]     present,
    input  logic [NSLOT-1:0]     ack_in,
    input  logic [NSLOT*8-1:0]   rx_bus,
    output logic [NSLOT-1:0]     strobe,
    output reply_t               reply
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign strobe[g] = present[g] && ((en && slot == SLOT_W'(g)) || extra[g]);
    end

    always_comb begin
        reply.data = FILL_BYTE;
        reply.ack  = 1'b0;
        if (en && present[slot]) begin
            reply.data = rx_bus[int'(slot)*8 +: 8];
            reply.ack  = ack_in[slot];
        end
    end

endmodule

// File: rtl/mtap_burst_buffer.sv
module mtap_burst_buffer
    import mtap_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= FILL_BYTE;
        end else if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    assign rd_data = mem[addr];

endmodule

// File: rtl/mtap_router.sv
module mtap_router
    import mtap_pkg::*;
#(
    parameter int         NSLOT       = 4,
    parameter int         BURST_LEN   = 8,
    parameter logic [7:0] ID_BYTE     = 8'h80,
    parameter logic [7:0] STATUS_BYTE = 8'h5A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_valid,
    input  logic [7:0]         step_byte,
    output logic               rsp_valid,
    output logic [7:0]         rsp_byte,
    output logic               rsp_ack,
    output logic [NSLOT-1:0]   pad_strobe,
    output logic [7:0]         pad_tx,
    input  logic [NSLOT*8-1:0] pad_rx,
    input  logic [NSLOT-1:0]   pad_ack,
    input  logic [NSLOT-1:0]   pad_present,
    output logic [NSLOT-1:0]   card_strobe,
    output logic [7:0]         card_tx,
    input  logic [NSLOT*8-1:0] card_rx,
    input  logic [NSLOT-1:0]   card_ack,
    input  logic [NSLOT-1:0]   card_present
);

    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int DEPTH  = NSLOT * BURST_LEN;
    localparam int STEP_W = $clog2(DEPTH);
    localparam int BEAT_W = $clog2(BURST_LEN);

    mtap_state_e         state_q, state_d;
    logic [SLOT_W-1:0]   slot_q, slot_d;
    logic [STEP_W-1:0]   step_q, step_d;
    logic                arm_q, arm_d;
    logic                bad_q, bad_d;
    logic                done_q, done_d;

    sel_t                dec;
    logic [SLOT_W-1:0]   dec_slot;
    logic [SLOT_W-1:0]   route_slot;
    logic                pad_en, card_en;
    logic [NSLOT-1:0]    pad_extra;
    logic [NSLOT-1:0]    no_extra;
    reply_t              pad_rep, card_rep;

    logic [7:0]          rsp_d;
    logic                ack_d;
    logic                buf_we;
    logic [7:0]          buf_wd, buf_rd;
    logic                at_idle;

    assign dec      = decode_first(step_byte, NSLOT);
    assign dec_slot = dec.idx[SLOT_W-1:0];
    assign no_extra = '0;
    assign at_idle  = (state_q == ST_IDLE);

    // Which device sees the byte this step, and what byte it sees.
    always_comb begin
        pad_en     = 1'b0;
        card_en    = 1'b0;
        pad_tx     = step_byte;
        card_tx    = step_byte;
        route_slot = slot_q;
        if (step_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    route_slot = dec_slot;
                    if (dec.hit_pad) begin
                        pad_en = 1'b1;
                        pad_tx = PAD_ACCESS;
                    end else if (dec.hit_card) begin
                        card_en = 1'b1;
                        card_tx = CARD_ACCESS;
                    end
                end
                ST_CARD:   card_en = 1'b1;
                ST_CMD:    pad_en  = ~arm_q;
                ST_REQ: begin
                    pad_en = ~arm_q;
                    pad_tx = 8'h00;
                end
                ST_SINGLE: pad_en = 1'b1;
                ST_BURST:  pad_en = ~done_q;
                default: ;
            endcase
        end
    end

    // Armed selection that is acknowledged also wakes the other controllers.
    always_comb begin
        pad_extra = '0;
        if (step_valid && at_idle && dec.hit_pad && arm_q && pad_rep.ack)
            pad_extra = ~(NSLOT'(1) << dec_slot);
    end

    mtap_port_fanout #(.NSLOT(NSLOT)) u_pad_fan (
        .en      (pad_en),
        .slot    (route_slot),
        .extra   (pad_extra),
        .present (pad_present),
        .ack_in  (pad_ack),
        .rx_bus  (pad_rx),
        .strobe  (pad_strobe),
        .reply   (pad_rep)
    );

    mtap_port_fanout #(.NSLOT(NSLOT)) u_card_fan (
        .en      (card_en),
        .slot    (route_slot),
        .extra   (no_extra),
        .present (card_present),
        .ack_in  (card_ack),
        .rx_bus  (card_rx),
        .strobe  (card_strobe),
        .reply   (card_rep)
    );

    mtap_burst_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_we),
        .addr    (step_q),
        .wr_data (buf_wd),
        .rd_data (buf_rd)
    );

    // Response and sequence progression.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        step_d  = step_q;
        arm_d   = arm_q;
        bad_d   = bad_q;
        done_d  = done_q;
        rsp_d   = FILL_BYTE;
        ack_d   = 1'b0;
        buf_we  = 1'b0;
        buf_wd  = FILL_BYTE;
        if (step_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (dec.hit_pad) begin
                        rsp_d   = pad_rep.data;
                        ack_d   = pad_rep.ack;
                        state_d = ST_CMD;
                        slot_d  = dec_slot;
                    end else if (dec.hit_card) begin
                        rsp_d   = card_rep.data;
                        ack_d   = card_rep.ack;
                        state_d = ST_CARD;
                        slot_d  = dec_slot;
                    end
                end
                ST_CARD: begin
                    rsp_d = card_rep.data;
                    ack_d = card_rep.ack;
                end
                ST_CMD: begin
                    if (arm_q) begin
                        rsp_d = ID_BYTE;
                        ack_d = 1'b1;
                        bad_d = (step_byte != BURST_CMD);
                    end else begin
                        rsp_d = pad_rep.data;
                        ack_d = pad_rep.ack;
                    end
                    state_d = ST_REQ;
                end
                ST_REQ: begin
                    if (arm_q) begin
                        rsp_d   = STATUS_BYTE;
                        ack_d   = ~bad_q;
                        state_d = ST_BURST;
                        slot_d  = '0;
                        step_d  = '0;
                        done_d  = 1'b0;
                    end else begin
                        rsp_d   = pad_rep.data;
                        ack_d   = pad_rep.ack;
                        state_d = ST_SINGLE;
                    end
                    arm_d = step_byte[0];
                end
                ST_SINGLE: begin
                    rsp_d = pad_rep.data;
                    ack_d = pad_rep.ack;
                end
                ST_BURST: begin
                    rsp_d  = buf_rd;
                    ack_d  = 1'b1;
                    buf_we = 1'b1;
                    if (!done_q) begin
                        buf_wd = pad_rep.data;
                        done_d = ~pad_rep.ack;
                    end
                    step_d = step_q + STEP_W'(1);
                    if (step_q[BEAT_W-1:0] == '1) begin
                        done_d = 1'b0;
                        slot_d = slot_q + SLOT_W'(1);
                        if (slot_q == SLOT_W'(NSLOT - 1)) ack_d = 1'b0;
                    end
                end
                default: ;
            endcase
            if (!ack_d) begin
                state_d = ST_IDLE;
                slot_d  = '0;
                step_d  = '0;
                done_d  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            slot_q    <= '0;
            step_q    <= '0;
            arm_q     <= 1'b0;
            bad_q     <= 1'b0;
            done_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_byte  <= FILL_BYTE;
            rsp_ack   <= 1'b0;
        end else begin
            state_q   <= state_d;
            slot_q    <= slot_d;
            step_q    <= step_d;
            arm_q     <= arm_d;
            bad_q     <= bad_d;
            done_q    <= done_d;
            rsp_valid <= step_valid;
            if (step_valid) begin
                rsp_byte <= rsp_d;
                rsp_ack  <= ack_d;
            end
        end
    end

endmodule

// File: rtl/mtap_router_chk.sv
module mtap_router_chk #(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             step_valid,
    input logic             rsp_valid,
    input logic             rsp_ack,
    input logic [NSLOT-1:0] pad_strobe,
    input logic [NSLOT-1:0] card_strobe,
    input logic             arm,
    input logic             at_idle
);

    p_rsp_follows_step_r12: assert property (@(posedge clk) disable iff (rst)
        step_valid |=> rsp_valid);

    p_no_stray_rsp_r12: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> !rsp_valid);

    p_nack_ends_seq_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ack) |-> at_idle);

    p_card_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(card_strobe) && !((|card_strobe) && (|pad_strobe)));

    p_strobe_needs_step_r3: assert property (@(posedge clk) disable iff (rst)
        ((|pad_strobe) || (|card_strobe)) |-> step_valid);

    p_fanout_when_armed_r8: assert property (@(posedge clk) disable iff (rst)
        ($countones(pad_strobe) > 1) |-> (arm && at_idle));

endmodule

bind mtap_router mtap_router_chk #(.NSLOT(NSLOT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .step_valid  (step_valid),
    .rsp_valid   (rsp_valid),
    .rsp_ack     (rsp_ack),
    .pad_strobe  (pad_strobe),
    .card_strobe (card_strobe),
    .arm         (arm_q),
    .at_idle     (at_idle)
);

// File: tb/mtap_router_test.sv
`timescale 1ns/1ps
module mtap_router_test;

    localparam int NS = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            step_valid = 1'b0;
    logic [7:0]      step_byte = 8'h00;
    logic            rsp_valid, rsp_ack;
    logic [7:0]      rsp_byte;
    logic [NS-1:0]   pad_strobe, card_strobe;
    logic [7:0]      pad_tx, card_tx;
    logic [NS*8-1:0] pad_rx, card_rx;
    logic [NS-1:0]   pad_ack, card_ack;
    logic [NS-1:0]   pad_present  = 4'b1011;
    logic [NS-1:0]   card_present = 4'b1010;

    int plen [NS] = '{4, 10, 0, 3};
    int clen [NS] = '{0, 3, 0, 5};
    int pcnt [NS];
    int ccnt [NS];
    int ecnt [NS];
    int eccnt[NS];

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] b;
        logic       a;
        string      tag;
    } exp_t;
    exp_t q[$];

    logic [7:0] ebuf[32];
    bit earm;
    bit ebad;

    always #2.5 clk = ~clk;

    mtap_router uut (
        .clk(clk), .rst(rst), .step_valid(step_valid), .step_byte(step_byte),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_ack(rsp_ack),
        .pad_strobe(pad_strobe), .pad_tx(pad_tx), .pad_rx(pad_rx),
        .pad_ack(pad_ack), .pad_present(pad_present),
        .card_strobe(card_strobe), .card_tx(card_tx), .card_rx(card_rx),
        .card_ack(card_ack), .card_present(card_present)
    );

    // Device models: reply = tx byte XOR a slot/count tag, ack while count < length.
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            pad_rx[s*8 +: 8]  = pad_tx ^ 8'((s << 6) | (pcnt[s] & 63));
            pad_ack[s]        = pcnt[s] < plen[s];
            card_rx[s*8 +: 8] = card_tx ^ 8'(8'h80 | (s << 4) | (ccnt[s] & 15));
            card_ack[s]       = ccnt[s] < clen[s];
        end
    end

    always @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (pad_strobe[s])  pcnt[s] = pcnt[s] + 1;
            if (card_strobe[s]) ccnt[s] = ccnt[s] + 1;
        end
    end

    task automatic dev_clear();
        for (int s = 0; s < NS; s++) begin
            pcnt[s] = 0; ccnt[s] = 0; ecnt[s] = 0; eccnt[s] = 0;
        end
    endtask

    task automatic pad_pred(input int s, input logic [7:0] tx,
                            output logic [7:0] r, output logic a);
        if (!pad_present[s]) begin
            r = 8'hFF; a = 1'b0;
        end else begin
            r = tx ^ 8'((s << 6) | (ecnt[s] & 63));
            a = ecnt[s] < plen[s];
            ecnt[s]++;
        end
    endtask

    task automatic card_pred(input int s, input logic [7:0] tx,
                             output logic [7:0] r, output logic a);
        if (!card_present[s]) begin
            r = 8'hFF; a = 1'b0;
        end else begin
            r = tx ^ 8'(8'h80 | (s << 4) | (eccnt[s] & 15));
            a = eccnt[s] < clen[s];
            eccnt[s]++;
        end
    endtask

    task automatic step(input logic [7:0] b, input logic [7:0] er,
                        input logic ea, input string tag);
        exp_t e;
        e.b = er; e.a = ea; e.tag = tag;
        q.push_back(e);
        step_valid = 1'b1;
        step_byte  = b;
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        step_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compares each response with the oldest expected item.
    always @(negedge clk) begin
        if (!rst && rsp_valid && !finished) begin
            vectors++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R12: response with no step, got %02h/%0d expected none",
                         rsp_byte, rsp_ack);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_byte !== e.b || rsp_ack !== e.a) begin
                    fails++;
                    $display("FAIL %s: got %02h ack %0d, expected %02h ack %0d",
                             e.tag, rsp_byte, rsp_ack, e.b, e.a);
                end
            end
        end
    end

    // One armed-or-plain controller sequence with burst handling.
    task automatic run_burst(input int sel, input logic [7:0] cmd,
                             input logic [7:0] req, input logic [7:0] base);
        logic [7:0] r;
        logic a;
        bit edone;
        pad_pred(sel, 8'h01, r, a);
        step(8'(sel + 1), r, a, "R1");
        if (!a) begin
            gap(1);
            return;
        end
        for (int s = 0; s < NS; s++)
            if (s != sel && pad_present[s]) ecnt[s]++;   // R8 access byte to others
        step(cmd, 8'h80, 1'b1, "R5");
        ebad = (cmd != 8'h42);
        step(req, 8'h5A, !ebad, "R6");
        earm = req[0];
        if (ebad) begin
            gap(1);
            return;
        end
        edone = 0;
        for (int i = 0; i < 32; i++) begin
            logic [7:0] hb;
            logic [7:0] old;
            hb  = base + 8'(i);
            old = ebuf[i];
            if (edone) ebuf[i] = 8'hFF;
            else begin
                pad_pred(i / 8, hb, r, a);
                ebuf[i] = r;
                edone = !a;
            end
            if (i % 8 == 7) edone = 0;
            step(hb, old, i != 31, (i % 8 == 7) ? "R10" : "R8 R9");
        end
        step(8'h07, 8'hFF, 1'b0, "R10");
        gap(1);
    endtask

    initial begin
        logic [7:0] r;
        logic a;
        dev_clear();
        for (int i = 0; i < 32; i++) ebuf[i] = 8'hFF;
        earm = 0;
        repeat (4) @(negedge clk);
        vectors++;
        if (rsp_valid !== 1'b0 || pad_strobe !== '0 || card_strobe !== '0) begin
            fails++;
            $display("FAIL R11: after reset valid %0d strobes %b/%b, expected 0",
                     rsp_valid, pad_strobe, card_strobe);
        end
        rst = 1'b0;
        @(negedge clk);

        // R3: unknown opening bytes and absent devices
        step(8'h00, 8'hFF, 1'b0, "R3");
        step(8'h05, 8'hFF, 1'b0, "R3");
        step(8'h85, 8'hFF, 1'b0, "R3");
        step(8'h03, 8'hFF, 1'b0, "R3");
        step(8'h81, 8'hFF, 1'b0, "R3");
        gap(2);

        // R2 and R4: card relay on slot 1
        dev_clear();
        card_pred(1, 8'h81, r, a);
        step(8'h82, r, a, "R2");
        for (int i = 0; i < 8 && a; i++) begin
            card_pred(1, 8'h3C + 8'(i), r, a);
            step(8'h3C + 8'(i), r, a, "R4");
        end
        step(8'h99, 8'hFF, 1'b0, "R4");
        gap(2);

        // R1 and R4: plain controller relay on slot 0
        dev_clear();
        pad_pred(0, 8'h01, r, a);
        step(8'h01, r, a, "R1");
        pad_pred(0, 8'h42, r, a);
        step(8'h42, r, a, "R4");
        pad_pred(0, 8'h00, r, a);
        step(8'h00, r, a, "R4");
        for (int i = 0; i < 12 && a; i++) begin
            pad_pred(0, 8'hA5, r, a);
            step(8'hA5, r, a, "R4");
        end
        gap(2);

        // R7: request bit 0 arms burst mode; slot 3 relay ends by nack
        dev_clear();
        pad_pred(3, 8'h01, r, a);
        step(8'h04, r, a, "R1");
        pad_pred(3, 8'h42, r, a);
        step(8'h42, r, a, "R4");
        pad_pred(3, 8'h00, r, a);
        step(8'h01, r, a, "R7");
        earm = 1;
        for (int i = 0; i < 12 && a; i++) begin
            pad_pred(3, 8'h5E, r, a);
            step(8'h5E, r, a, "R4");
        end
        gap(2);

        // R5 R6 R9 R10 R11: first burst returns reset fill, gathers replies
        dev_clear();
        run_burst(1, 8'h42, 8'h01, 8'h00);
        // Second burst replays what the first gathered (R8 counts visible here)
        dev_clear();
        run_burst(0, 8'h42, 8'h01, 8'h10);
        // Absent selected slot while armed (R3)
        dev_clear();
        run_burst(2, 8'h42, 8'h01, 8'h00);
        // Invalid command: ID acked, status not acked, disarms (R5 R6 R7)
        dev_clear();
        run_burst(3, 8'h17, 8'h00, 8'h00);

        // R7: disarmed, so the command byte passes through again
        dev_clear();
        pad_pred(1, 8'h01, r, a);
        step(8'h02, r, a, "R1");
        pad_pred(1, 8'h42, r, a);
        step(8'h42, r, a, "R7");
        pad_pred(1, 8'h00, r, a);
        step(8'h00, r, a, "R4");
        for (int i = 0; i < 16 && a; i++) begin
            pad_pred(1, 8'h33, r, a);
            step(8'h33, r, a, "R4");
        end
        gap(4);

        if (q.size() != 0) begin
            fails++;
            $display("FAIL R12: %0d responses missing, expected 0", q.size());
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL R12: watchdog expired, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule